// File: doc/BRIEF.md
# Binary32 Compare Unit

This block compares two IEEE-754 single-precision operands, `a` and `b`. It produces a signed three-way result code, two condition flags shaped like the zero and carry flags a processor keeps, and one boolean output for each relation. A NaN operand makes the pair unordered. The code returned for an unordered pair is chosen per operation by a single select input. The usual setting gives +1, which suits compare, less-than, less-or-equal, equality and inequality. The other setting gives -1, which suits greater-than and greater-or-equal. The boolean relation outputs are always false for an unordered pair.

The compare datapath is combinational. The `REG_OUT` parameter places one output register stage after it, and the default is registered. When the outputs are registered, a reset loads them with the result of comparing +0 with +0, so they are consistent from the start. Signed zeros compare equal. Infinities take part as ordinary values. Signalling-NaN exceptions are not raised, and no total-order mode is provided.

Top module: `fcmp_unit`

## Requirements
- R1: `code_o` is 2'b11 (-1) when a < b, 2'b00 when a == b and 2'b01 (+1) when a > b, for an ordered pair; 2'b10 never appears.
- R2: An operand is NaN when its exponent field [30:23] is all ones and its fraction [22:0] is nonzero. If either operand is NaN, `code_o` is 2'b01 while `unord_neg_i` is 0, and 2'b11 while it is 1.
- R3: +0 (0x00000000) and -0 (0x80000000) compare equal in every output, including against each other.
- R4: An infinity (exponent all ones, fraction zero) is ordered. It is greater than every finite value of its sign when positive, and less than every finite value of its sign when negative.
- R5: When the signs (bit 31) differ and the pair is not two zeros, the negative operand is the lesser one. With equal signs, the larger magnitude is greater for positive operands and lesser for negative operands.
- R6: `zero_o` is 1 exactly when `code_o` is 2'b00.
- R7: `carry_o` is 0 exactly when `code_o` is 2'b11. This means a < b, or an unordered pair with the -1 policy selected.
- R8: `eq_o`, `lt_o` and `le_o` are 1 only for a true relation a==b, a<b and a<=b, and they are 0 for an unordered pair.
- R9: `gt_o` and `ge_o` are formed by comparing with the operands swapped, as b<a and b<=a, and they are 0 for an unordered pair.
- R10: `unord_o` is 1 exactly when at least one operand is NaN. While it is 1, all five relation outputs are 0. While it is 0, exactly one of `lt_o`, `eq_o` and `gt_o` is 1.
- R11: With `REG_OUT`=1, the outputs present the compare of the inputs sampled at the previous rising clock edge. While `rst_ni` is low, the outputs show the +0 versus +0 result: code 2'b00, `zero_o`, `carry_o`, `eq_o`, `le_o` and `ge_o` at 1, and the others at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 32 | First operand, binary32 |
| b_i | input | 32 | Second operand, binary32 |
| unord_neg_i | input | 1 | Unordered policy: 0 gives +1, 1 gives -1 |
| code_o | output | 2 | Signed result code (-1, 0, +1) |
| zero_o | output | 1 | Set when the operands are equal |
| carry_o | output | 1 | Cleared when the result code is -1 |
| eq_o | output | 1 | a == b |
| lt_o | output | 1 | a < b |
| le_o | output | 1 | a <= b |
| ge_o | output | 1 | a >= b |
| gt_o | output | 1 | a > b |
| unord_o | output | 1 | At least one operand is NaN |

## Verification
Three functions can meet on the same vector: NaN detection, signed-zero equality and the sign-decides-order rule. The stimulus provokes this with a NaN against a zero of either sign, a NaN against an infinity, and a NaN with its sign bit set. In each of these cases NaN detection must override both the zero equality and the sign rule, and `unord_neg_i` is flipped on the same vector. The behavioural model reduces each ordered operand to a signed integer key with both zeros mapped to 0. It judges code, flags and predicates against that key for every vector. For an unordered pair it expects the policy code and all relation outputs low.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef struct packed {
    logic [1:0] code;
    logic       zf;
    logic       cf;
    logic       eq;
    logic       lt;
    logic       le;
    logic       ge;
    logic       gt;
    logic       un;
  } fcmp_res_t;

  localparam logic [1:0] CODE_LT = 2'b11;
  localparam logic [1:0] CODE_EQ = 2'b00;
  localparam logic [1:0] CODE_GT = 2'b01;

  // state equal to comparing +0 with +0
  localparam fcmp_res_t RES_IDLE = '{code: CODE_EQ, zf: 1'b1, cf: 1'b1, eq: 1'b1,
                                     lt: 1'b0, le: 1'b1, ge: 1'b1, gt: 1'b0, un: 1'b0};
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0]   op_i,
  output logic           nan_o,
  output logic           zero_o,
  output logic           sign_o,
  output logic [W-2:0]   mag_o
);
  logic exp_max;
  assign exp_max = &op_i[W-2:MAN_W];
  assign nan_o   = exp_max && (op_i[MAN_W-1:0] != '0);
  assign zero_o  = (op_i[W-2:0] == '0);
  assign sign_o  = op_i[W-1];
  assign mag_o   = op_i[W-2:0];
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
  parameter int MAG_W = 31
) (
  input  logic             x_sign_i,
  input  logic             x_zero_i,
  input  logic [MAG_W-1:0] x_mag_i,
  input  logic             y_sign_i,
  input  logic             y_zero_i,
  input  logic [MAG_W-1:0] y_mag_i,
  output logic             less_o,
  output logic             same_o
);
  logic mag_lt, mag_gt, mag_eq;
  assign mag_lt = x_mag_i < y_mag_i;
  assign mag_gt = x_mag_i > y_mag_i;
  assign mag_eq = x_mag_i == y_mag_i;

  always_comb begin
    if (x_zero_i && y_zero_i) begin
      less_o = 1'b0;
      same_o = 1'b1;
    end else if (x_sign_i != y_sign_i) begin
      less_o = x_sign_i;
      same_o = 1'b0;
    end else begin
      // negative pair reverses magnitude order
      less_o = x_sign_i ? mag_gt : mag_lt;
      same_o = mag_eq;
    end
  end
endmodule

// File: rtl/fcmp_encode.sv
module fcmp_encode
  import fcmp_pkg::*;
(
  input  logic      lt_ab_i,
  input  logic      eq_ab_i,
  input  logic      lt_ba_i,
  input  logic      unord_i,
  input  logic      unord_neg_i,
  output fcmp_res_t res_o
);
  always_comb begin
    if (unord_i)       res_o.code = unord_neg_i ? CODE_LT : CODE_GT;
    else if (lt_ab_i)  res_o.code = CODE_LT;
    else if (eq_ab_i)  res_o.code = CODE_EQ;
    else               res_o.code = CODE_GT;
    res_o.zf = (res_o.code == CODE_EQ);
    res_o.cf = (res_o.code != CODE_LT);
    res_o.eq = !unord_i && eq_ab_i;
    res_o.lt = !unord_i && lt_ab_i;
    res_o.le = !unord_i && (lt_ab_i || eq_ab_i);
    res_o.gt = !unord_i && lt_ba_i;
    res_o.ge = !unord_i && (lt_ba_i || eq_ab_i);
    res_o.un = unord_i;
  end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter bit REG_OUT = 1'b1,
  localparam int W      = 1 + EXP_W + MAN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         unord_neg_i,
  output logic [1:0]   code_o,
  output logic         zero_o,
  output logic         carry_o,
  output logic         eq_o,
  output logic         lt_o,
  output logic         le_o,
  output logic         ge_o,
  output logic         gt_o,
  output logic         unord_o
);
  logic [W-1:0] ops [2];
  logic         nan  [2];
  logic         zer  [2];
  logic         sgn  [2];
  logic [W-2:0] mag  [2];
  logic         less [2];
  logic         same [2];

  assign ops[0] = a_i;
  assign ops[1] = b_i;

  for (genvar i = 0; i < 2; i++) begin : g_side
    fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op_i  (ops[i]),
      .nan_o (nan[i]),
      .zero_o(zer[i]),
      .sign_o(sgn[i]),
      .mag_o (mag[i])
    );
    // i=0: a against b; i=1: swapped operands
    fcmp_order #(.MAG_W(W-1)) u_ord (
      .x_sign_i(sgn[i]),
      .x_zero_i(zer[i]),
      .x_mag_i (mag[i]),
      .y_sign_i(sgn[1-i]),
      .y_zero_i(zer[1-i]),
      .y_mag_i (mag[1-i]),
      .less_o  (less[i]),
      .same_o  (same[i])
    );
  end

  fcmp_res_t res_d, res_q;

  fcmp_encode u_enc (
    .lt_ab_i    (less[0]),
    .eq_ab_i    (same[0]),
    .lt_ba_i    (less[1]),
    .unord_i    (nan[0] || nan[1]),
    .unord_neg_i(unord_neg_i),
    .res_o      (res_d)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) res_q <= RES_IDLE;
      else         res_q <= res_d;
    end
  end else begin : g_comb
    assign res_q = res_d;
  end

  assign code_o  = res_q.code;
  assign zero_o  = res_q.zf;
  assign carry_o = res_q.cf;
  assign eq_o    = res_q.eq;
  assign lt_o    = res_q.lt;
  assign le_o    = res_q.le;
  assign ge_o    = res_q.ge;
  assign gt_o    = res_q.gt;
  assign unord_o = res_q.un;
endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] code_o,
  input logic       zero_o,
  input logic       carry_o,
  input logic       eq_o,
  input logic       lt_o,
  input logic       le_o,
  input logic       ge_o,
  input logic       gt_o,
  input logic       unord_o
);
  a_r1_no_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o != 2'b10);
  a_r1_code_tracks_lt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lt_o |-> code_o == 2'b11);
  a_r2_unord_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unord_o |-> (code_o == 2'b01 || code_o == 2'b11));
  a_r6_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o == eq_o);
  a_r7_carry_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_o == (code_o == 2'b11));
  a_r8_le_union: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_o == (lt_o || eq_o));
  a_r9_ge_union: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ge_o == (gt_o || eq_o));
  a_r10_unord_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unord_o |-> !(eq_o || lt_o || le_o || ge_o || gt_o));
  a_r10_one_relation: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unord_o |-> $countones({lt_o, eq_o, gt_o}) == 1);
endmodule

bind fcmp_unit fcmp_unit_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .code_o (code_o),
  .zero_o (zero_o),
  .carry_o(carry_o),
  .eq_o   (eq_o),
  .lt_o   (lt_o),
  .le_o   (le_o),
  .ge_o   (ge_o),
  .gt_o   (gt_o),
  .unord_o(unord_o)
);

// File: tb/fcmp_unit_bench.sv
module fcmp_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        unord_neg_i = 1'b0;
  logic [1:0]  code_o;
  logic        zero_o, carry_o, eq_o, lt_o, le_o, ge_o, gt_o, unord_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  fcmp_unit u_fcmp_unit (
    .clk_i, .rst_ni, .a_i, .b_i, .unord_neg_i,
    .code_o, .zero_o, .carry_o, .eq_o, .lt_o, .le_o, .ge_o, .gt_o, .unord_o
  );

  typedef struct {
    logic [1:0] code;
    bit zf, cf, eq, lt, le, ge, gt, un;
  } exp_t;

  exp_t q[$];

  function automatic bit is_nan(logic [31:0] v);
    return (v[30:23] == 8'hff) && (v[22:0] != 0);
  endfunction

  // signed integer key: both zeros map to 0, order matches real order
  function automatic longint key(logic [31:0] v);
    longint m = longint'(v[30:0]);
    return v[31] ? -m : m;
  endfunction

  function automatic exp_t model(logic [31:0] a, logic [31:0] b, bit neg);
    exp_t e;
    longint ka = key(a), kb = key(b);
    e.un = is_nan(a) || is_nan(b);
    e.eq = !e.un && ka == kb;
    e.lt = !e.un && ka < kb;
    e.gt = !e.un && ka > kb;
    e.le = e.eq || e.lt;
    e.ge = e.eq || e.gt;
    if (e.un)      e.code = neg ? 2'b11 : 2'b01;
    else if (e.lt) e.code = 2'b11;
    else if (e.gt) e.code = 2'b01;
    else           e.code = 2'b00;
    e.zf = e.code == 2'b00;
    e.cf = e.code != 2'b11;
    return e;
  endfunction

  task automatic cmp1(string tag, logic act, logic exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h sel=%0b act=%0b exp=%0b", tag, a_i, b_i, unord_neg_i, act, exp);
    end
  endtask

  task automatic judge(exp_t e, string ctx);
    n_vec++;
    if (code_o !== e.code) begin
      n_bad++;
      $display("FAIL R1/R2 code %s act=%b exp=%b", ctx, code_o, e.code);
    end
    cmp1({"R6 zero ", ctx},  zero_o,  e.zf);
    cmp1({"R7 carry ", ctx}, carry_o, e.cf);
    cmp1({"R8 eq ", ctx},    eq_o,    e.eq);
    cmp1({"R8 lt ", ctx},    lt_o,    e.lt);
    cmp1({"R8 le ", ctx},    le_o,    e.le);
    cmp1({"R9 ge ", ctx},    ge_o,    e.ge);
    cmp1({"R9 gt ", ctx},    gt_o,    e.gt);
    cmp1({"R10 unord ", ctx}, unord_o, e.un);
  endtask

  // drive at negedge, register captures at posedge, judge at next negedge (R11)
  task automatic apply(logic [31:0] a, logic [31:0] b, bit neg, string ctx);
    a_i = a; b_i = b; unord_neg_i = neg;
    q.push_back(model(a, b, neg));
    @(posedge clk_i);
    @(negedge clk_i);
    judge(q.pop_front(), ctx);
  endtask

  function automatic logic [31:0] pick(int r);
    case (r % 12)
      0:  return 32'h0000_0000;
      1:  return 32'h8000_0000;
      2:  return 32'h7f80_0000;
      3:  return 32'hff80_0000;
      4:  return 32'h7fc0_0000 | ($urandom & 32'h803f_ffff);
      5:  return 32'h7f80_0001;
      6:  return 32'h0000_0001 + ($urandom & 32'h807f_fffe);
      7:  return 32'h7f7f_ffff;
      8:  return 32'h3f80_0000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    exp_t idle;
    idle = model(32'h0, 32'h0, 1'b0);
    repeat (3) @(negedge clk_i);
    judge(idle, "R11 reset state");
    rst_ni = 1'b1;
    @(negedge clk_i);
    judge(idle, "R11 after release");

    apply(32'h3f80_0000, 32'h4000_0000, 0, "R1 1<2");
    apply(32'h4000_0000, 32'h3f80_0000, 0, "R1 2>1");
    apply(32'h4049_0fdb, 32'h4049_0fdb, 0, "R1 equal");
    apply(32'h0000_0000, 32'h8000_0000, 0, "R3 +0 vs -0");
    apply(32'h8000_0000, 32'h0000_0000, 1, "R3 -0 vs +0");
    apply(32'hbf80_0000, 32'hc000_0000, 0, "R5 -1 > -2");
    apply(32'hbf80_0000, 32'h3f80_0000, 0, "R5 sign decides");
    apply(32'h8000_0001, 32'h0000_0000, 0, "R5 -denorm < +0");
    apply(32'h0000_0001, 32'h8000_0000, 0, "R5 +denorm > -0");
    apply(32'h7f80_0000, 32'h7f7f_ffff, 0, "R4 +inf > max");
    apply(32'hff80_0000, 32'hff7f_ffff, 0, "R4 -inf < -max");
    apply(32'h7f80_0000, 32'h7f80_0000, 0, "R4 inf == inf");
    apply(32'h7fc0_0000, 32'h3f80_0000, 0, "R2 nan policy +1");
    apply(32'h7fc0_0000, 32'h3f80_0000, 1, "R2 nan policy -1");
    apply(32'h0000_0000, 32'h7f80_0001, 1, "R10 +0 vs nan");
    apply(32'hffc0_0000, 32'h8000_0000, 0, "R10 -nan vs -0");
    apply(32'h7f80_0000, 32'hff80_0001, 1, "R2 inf vs -nan");
    apply(32'h7fff_ffff, 32'h7fff_ffff, 0, "R10 nan vs same nan");
    apply(32'h3f80_0000, 32'h3f80_0001, 1, "R7 lt sets code -1");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = pick($urandom);
      b = (i % 7 == 0) ? a : pick($urandom);
      apply(a, b, 1'($urandom), "R1 random");
    end

    rst_ni = 1'b0;
    @(negedge clk_i);
    judge(idle, "R11 mid-run reset");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 50000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired act=%0d cycles exp=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule